// File: doc/BRIEF.md
# Configuration Access Engine

This block performs a single configuration-space read or write toward one downstream device. Software prepares the access through a small register file: a control word selecting the access kind, a low and a high address word, the write data and a byte-enable mask. Writing a one into the go register launches the access. The engine copies the prepared fields at launch and presents them on a valid/ready request port to a link-layer model. It then waits for one response beat carrying read data and a 3-bit completion code.

Completion is visible in two ways. The go register reads back zero again. A sticky interrupt status bit is set and drives the `irq` pin until software writes one to it. A programmable cycle limit bounds the wait. When the limit expires, the engine completes on its own with all-ones read data and a timeout code. An unknown access kind completes at once and sends no request.

Top module: `cfg_pio_engine`

Register byte offsets used below: GO 0x00, CTRL 0x04, IRQSTAT 0x08, CPLSTAT 0x0C, ADDRLO 0x10, ADDRHI 0x14, WDATA 0x18, BYTEEN 0x1C, RDATA 0x20, LIMIT 0x24. Reads return data combinationally on `reg_rdata` for the offset on `reg_addr`. Writes take effect at the clock edge where `reg_we` is high.

## Requirements
- R1: After reset, GO, IRQSTAT, CPLSTAT, RDATA and CTRL read 0, BYTEEN reads 0xF, LIMIT reads the default of 1000, and `req_valid`, `irq` and `win_disable` are low.
- R2: CTRL bits [3:0] select the access kind, which sets `req_write` and `req_type1` for the launched request. 0x8 is a type 0 read (0,0). 0x9 is a type 1 read (0,1). 0xA is a type 0 write (1,0). 0xB is a type 1 write (1,1).
- R3: CTRL bit 24 is stored apart from the kind field and drives `win_disable`. All other CTRL bits read back as 0.
- R4: Writing 1 to GO bit 0 while idle with a valid kind launches the access. `req_valid` rises in the next cycle and stays high until `req_ready` is seen. The request carries ADDRLO verbatim (bus in [27:20], device in [19:15], function in [14:12], offset below), together with ADDRHI, WDATA and BYTEEN. GO bit 0 reads 1 while the access is in flight.
- R5: On the response beat, GO reads 0 in the next cycle and IRQSTAT bit 0 sets, which raises `irq`. CPLSTAT bits [9:7] take `rsp_status`. For a read, RDATA takes `rsp_data`.
- R6: Writing 1 to IRQSTAT bit 0 clears it. Writing 0 to it has no effect. A completion in the same cycle as a clear leaves the bit set.
- R7: A write access completing normally leaves RDATA unchanged.
- R8: While an access is in flight, a further GO write of 1 starts nothing, and rewriting the address, data or mask registers does not alter the request in flight.
- R9: Writing 0 to GO while busy abandons the access. GO reads 0, `req_valid` drops, IRQSTAT is not set, and a later response is ignored.
- R10: An access still pending LIMIT cycles after launch completes on its own. RDATA becomes 0xFFFFFFFF and CPLSTAT [9:7] becomes 3'b101. A LIMIT of 0 disables the timeout.
- R11: A launch with any other kind code completes in the launch cycle with CPLSTAT [9:7] = 3'b111 and no request, and RDATA is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| irq | output | 1 | Completion interrupt level |
| win_disable | output | 1 | Stored address-window disable bit |
| req_valid | output | 1 | Request present |
| req_ready | input | 1 | Link model accepts request |
| req_write | output | 1 | Request is a write |
| req_type1 | output | 1 | Request is type 1 (beyond the first bus) |
| req_addr_lo | output | 32 | Low address word |
| req_addr_hi | output | 32 | High address word |
| req_wdata | output | 32 | Write data |
| req_strb | output | 4 | Byte enables |
| rsp_valid | input | 1 | Response beat |
| rsp_data | input | 32 | Response read data |
| rsp_status | input | 3 | Response completion code |

## Verification
The assertions assume the link model sends a response only after it has accepted a request. They also assume software never writes GO while an invalid kind is pending in the same cycle as a completion. Nothing is assumed about how long the model takes. The bench drives `req_ready` and `rsp_valid` only from its own scenario tasks, one beat at a time, after the request it answers is visible. It sends one stray response after an abandon to probe R9, and it otherwise leaves the model silent to reach the timeout.

// File: rtl/cfg_pio_pkg.sv
package cfg_pio_pkg;

   localparam int CFG_DW = 32;
   localparam int CFG_SW = CFG_DW / 8;

   // register byte offsets
   localparam int OFF_GO      = 'h00;
   localparam int OFF_CTRL    = 'h04;
   localparam int OFF_IRQSTAT = 'h08;
   localparam int OFF_CPLSTAT = 'h0C;
   localparam int OFF_ADDRLO  = 'h10;
   localparam int OFF_ADDRHI  = 'h14;
   localparam int OFF_WDATA   = 'h18;
   localparam int OFF_BYTEEN  = 'h1C;
   localparam int OFF_RDATA   = 'h20;
   localparam int OFF_LIMIT   = 'h24;

   localparam int WIN_BIT = 24;
   localparam int CPL_LSB = 7;
   localparam int CPL_W   = 3;

   localparam logic [CPL_W-1:0] CPL_OK    = 3'b000;
   localparam logic [CPL_W-1:0] CPL_TMO   = 3'b101;
   localparam logic [CPL_W-1:0] CPL_BADTY = 3'b111;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_RSP  = 2'd2
   } eng_state_e;

   typedef struct packed {
      logic [CFG_DW-1:0] addr_lo;
      logic [CFG_DW-1:0] addr_hi;
      logic [CFG_DW-1:0] wdata;
      logic [CFG_SW-1:0] strb;
   } cfg_req_t;

endpackage

// File: rtl/cfg_pio_regs.sv
module cfg_pio_regs
   import cfg_pio_pkg::*;
#(
   parameter int RA_W        = 6,
   parameter int TMO_W       = 16,
   parameter int TMO_DEFAULT = 1000
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_we,
   input  logic [RA_W-1:0]      reg_addr,
   input  logic [CFG_DW-1:0]    reg_wdata,
   output logic [CFG_DW-1:0]    reg_rdata,
   input  logic                 busy_i,
   input  logic                 done_i,
   input  logic [CPL_W-1:0]     cpl_i,
   input  logic                 rdata_load_i,
   input  logic [CFG_DW-1:0]    rdata_i,
   output logic                 launch_o,
   output logic                 abort_o,
   output logic [3:0]           kind_o,
   output cfg_req_t             req_o,
   output logic [TMO_W-1:0]     limit_o,
   output logic                 win_dis_o,
   output logic                 irq_o
);

   localparam logic [RA_W-1:0] A_GO      = RA_W'(OFF_GO);
   localparam logic [RA_W-1:0] A_CTRL    = RA_W'(OFF_CTRL);
   localparam logic [RA_W-1:0] A_IRQSTAT = RA_W'(OFF_IRQSTAT);
   localparam logic [RA_W-1:0] A_CPLSTAT = RA_W'(OFF_CPLSTAT);
   localparam logic [RA_W-1:0] A_ADDRLO  = RA_W'(OFF_ADDRLO);
   localparam logic [RA_W-1:0] A_ADDRHI  = RA_W'(OFF_ADDRHI);
   localparam logic [RA_W-1:0] A_WDATA   = RA_W'(OFF_WDATA);
   localparam logic [RA_W-1:0] A_BYTEEN  = RA_W'(OFF_BYTEEN);
   localparam logic [RA_W-1:0] A_RDATA   = RA_W'(OFF_RDATA);
   localparam logic [RA_W-1:0] A_LIMIT   = RA_W'(OFF_LIMIT);

   logic [3:0]          kind_q;
   logic                win_q;
   logic [CFG_DW-1:0]   addr_lo_q, addr_hi_q, wdata_q, rdata_q;
   logic [CFG_SW-1:0]   strb_q;
   logic [TMO_W-1:0]    limit_q;
   logic                irq_q;
   logic [CPL_W-1:0]    cpl_q;

   logic wr_go, wr_ctrl, wr_irq, wr_alo, wr_ahi, wr_wd, wr_be, wr_lim;

   assign wr_go   = reg_we && (reg_addr == A_GO);
   assign wr_ctrl = reg_we && (reg_addr == A_CTRL);
   assign wr_irq  = reg_we && (reg_addr == A_IRQSTAT);
   assign wr_alo  = reg_we && (reg_addr == A_ADDRLO);
   assign wr_ahi  = reg_we && (reg_addr == A_ADDRHI);
   assign wr_wd   = reg_we && (reg_addr == A_WDATA);
   assign wr_be   = reg_we && (reg_addr == A_BYTEEN);
   assign wr_lim  = reg_we && (reg_addr == A_LIMIT);

   assign launch_o = wr_go &&  reg_wdata[0] && !busy_i;
   assign abort_o  = wr_go && !reg_wdata[0] &&  busy_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind_q    <= '0;
         win_q     <= 1'b0;
         addr_lo_q <= '0;
         addr_hi_q <= '0;
         wdata_q   <= '0;
         strb_q    <= '1;
         limit_q   <= TMO_W'(TMO_DEFAULT);
      end else begin
         if (wr_ctrl) begin
            kind_q <= reg_wdata[3:0];
            win_q  <= reg_wdata[WIN_BIT];
         end
         if (wr_alo) addr_lo_q <= reg_wdata;
         if (wr_ahi) addr_hi_q <= reg_wdata;
         if (wr_wd)  wdata_q   <= reg_wdata;
         if (wr_be)  strb_q    <= reg_wdata[CFG_SW-1:0];
         if (wr_lim) limit_q   <= reg_wdata[TMO_W-1:0];
      end
   end

   // completion side: sticky status wins over a same-cycle clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q   <= 1'b0;
         cpl_q   <= CPL_OK;
         rdata_q <= '0;
      end else begin
         if (done_i)
            irq_q <= 1'b1;
         else if (wr_irq && reg_wdata[0])
            irq_q <= 1'b0;
         if (done_i)
            cpl_q <= cpl_i;
         if (done_i && rdata_load_i)
            rdata_q <= rdata_i;
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_GO:      reg_rdata[0] = busy_i;
         A_CTRL: begin
            reg_rdata[3:0]     = kind_q;
            reg_rdata[WIN_BIT] = win_q;
         end
         A_IRQSTAT: reg_rdata[0] = irq_q;
         A_CPLSTAT: reg_rdata[CPL_LSB +: CPL_W] = cpl_q;
         A_ADDRLO:  reg_rdata = addr_lo_q;
         A_ADDRHI:  reg_rdata = addr_hi_q;
         A_WDATA:   reg_rdata = wdata_q;
         A_BYTEEN:  reg_rdata[CFG_SW-1:0] = strb_q;
         A_RDATA:   reg_rdata = rdata_q;
         A_LIMIT:   reg_rdata = CFG_DW'(limit_q);
         default:   reg_rdata = '0;
      endcase
   end

   assign kind_o        = kind_q;
   assign req_o.addr_lo = addr_lo_q;
   assign req_o.addr_hi = addr_hi_q;
   assign req_o.wdata   = wdata_q;
   assign req_o.strb    = strb_q;
   assign limit_o       = limit_q;
   assign win_dis_o     = win_q;
   assign irq_o         = irq_q;

   AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
      done_i |=> irq_q); // R5
   AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q && !(wr_irq && reg_wdata[0]) |=> irq_q); // R6

endmodule

// File: rtl/cfg_pio_timer.sv
module cfg_pio_timer #(
   parameter int TMO_W = 16,
   parameter bit EN    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             launch_i,
   input  logic             busy_i,
   input  logic [TMO_W-1:0] limit_i,
   output logic             expire_o
);

   localparam logic [TMO_W-1:0] ONE = TMO_W'(1);

   if (EN) begin : g_timer
      logic [TMO_W-1:0] cnt_q;
      logic [TMO_W-1:0] lim_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q <= '0;
            lim_q <= '0;
         end else if (launch_i) begin
            cnt_q <= '0;
            lim_q <= limit_i;
         end else if (busy_i) begin
            cnt_q <= cnt_q + ONE;
         end
      end

      assign expire_o = busy_i && (lim_q != '0) && (cnt_q == lim_q - ONE);

      AST_TMO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
         busy_i && (lim_q != '0) |-> cnt_q < lim_q); // R10
   end else begin : g_no_timer
      assign expire_o = 1'b0;
   end

endmodule

// File: rtl/cfg_pio_fsm.sv
module cfg_pio_fsm
   import cfg_pio_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch_i,
   input  logic              abort_i,
   input  logic [3:0]        kind_i,
   input  cfg_req_t          req_i,
   input  logic              expire_i,
   input  logic              req_ready,
   input  logic              rsp_valid,
   input  logic [CFG_DW-1:0] rsp_data,
   input  logic [CPL_W-1:0]  rsp_status,
   output logic              busy_o,
   output logic              done_o,
   output logic [CPL_W-1:0]  cpl_o,
   output logic              rdata_load_o,
   output logic [CFG_DW-1:0] rdata_o,
   output logic              req_valid,
   output logic              req_write,
   output logic              req_type1,
   output cfg_req_t          req_o
);

   eng_state_e state_q;
   logic       wr_q, t1_q;
   cfg_req_t   fld_q;
   logic       kind_ok;

   // codes 0x8..0xB: bit 1 selects write, bit 0 selects type 1
   assign kind_ok = (kind_i[3:2] == 2'b10);

   always_comb begin
      done_o       = 1'b0;
      cpl_o        = CPL_OK;
      rdata_load_o = 1'b0;
      rdata_o      = rsp_data;
      case (state_q)
         ST_IDLE: begin
            if (launch_i && !kind_ok) begin
               done_o = 1'b1;
               cpl_o  = CPL_BADTY;
            end
         end
         ST_REQ: begin
            if (!abort_i && expire_i) begin
               done_o       = 1'b1;
               cpl_o        = CPL_TMO;
               rdata_load_o = 1'b1;
               rdata_o      = '1;
            end
         end
         ST_RSP: begin
            if (!abort_i) begin
               if (rsp_valid) begin
                  done_o       = 1'b1;
                  cpl_o        = rsp_status;
                  rdata_load_o = !wr_q;
               end else if (expire_i) begin
                  done_o       = 1'b1;
                  cpl_o        = CPL_TMO;
                  rdata_load_o = 1'b1;
                  rdata_o      = '1;
               end
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         wr_q    <= 1'b0;
         t1_q    <= 1'b0;
         fld_q   <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (launch_i && kind_ok) begin
                  state_q <= ST_REQ;
                  wr_q    <= kind_i[1];
                  t1_q    <= kind_i[0];
                  fld_q   <= req_i;
               end
            end
            ST_REQ: begin
               if (abort_i || done_o)
                  state_q <= ST_IDLE;
               else if (req_ready)
                  state_q <= ST_RSP;
            end
            ST_RSP: begin
               if (abort_i || done_o)
                  state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o    = (state_q != ST_IDLE);
   assign req_valid = (state_q == ST_REQ);
   assign req_write = wr_q;
   assign req_type1 = t1_q;
   assign req_o     = fld_q;

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_ready && !abort_i && !expire_i |=> req_valid); // R4
   AST_KIND_MAP: assert property (@(posedge clk) disable iff (!rst_n)
      launch_i && kind_ok |=> req_write == $past(kind_i[1]) && req_type1 == $past(kind_i[0])); // R2
   AST_FIELDS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> $stable(req_o) && $stable(req_write)); // R8
   AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      abort_i |=> !busy_o && !req_valid); // R9
   AST_BADKIND_NOREQ: assert property (@(posedge clk) disable iff (!rst_n)
      launch_i && !kind_ok |=> !req_valid); // R11
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !busy_o); // R5

endmodule

// File: rtl/cfg_pio_engine.sv
module cfg_pio_engine
   import cfg_pio_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int RA_W        = 6,
   parameter int TMO_W       = 16,
   parameter int TMO_DEFAULT = 1000,
   parameter bit TIMEOUT_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [RA_W-1:0]   reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq,
   output logic              win_disable,
   output logic              req_valid,
   input  logic              req_ready,
   output logic              req_write,
   output logic              req_type1,
   output logic [DATA_W-1:0] req_addr_lo,
   output logic [DATA_W-1:0] req_addr_hi,
   output logic [DATA_W-1:0] req_wdata,
   output logic [DATA_W/8-1:0] req_strb,
   input  logic              rsp_valid,
   input  logic [DATA_W-1:0] rsp_data,
   input  logic [2:0]        rsp_status
);

   if (DATA_W != CFG_DW) begin : g_bad_dw
      $error("cfg_pio_engine: DATA_W must be 32");
   end
   if (RA_W < 6) begin : g_bad_ra
      $error("cfg_pio_engine: RA_W too small for the register map");
   end
   if (TMO_W < 1 || TMO_W > CFG_DW) begin : g_bad_tw
      $error("cfg_pio_engine: TMO_W out of range");
   end
   if (TMO_DEFAULT < 0 || TMO_DEFAULT >= (64'd1 << TMO_W)) begin : g_bad_td
      $error("cfg_pio_engine: TMO_DEFAULT does not fit TMO_W");
   end

   logic              busy, done, launch, abort, rd_load, expire;
   logic [CPL_W-1:0]  cpl;
   logic [CFG_DW-1:0] rd_val;
   logic [3:0]        kind;
   logic [TMO_W-1:0]  limit;
   cfg_req_t          prog_req, live_req;

   cfg_pio_regs #(
      .RA_W        (RA_W),
      .TMO_W       (TMO_W),
      .TMO_DEFAULT (TMO_DEFAULT)
   ) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .reg_we       (reg_we),
      .reg_addr     (reg_addr),
      .reg_wdata    (reg_wdata),
      .reg_rdata    (reg_rdata),
      .busy_i       (busy),
      .done_i       (done),
      .cpl_i        (cpl),
      .rdata_load_i (rd_load),
      .rdata_i      (rd_val),
      .launch_o     (launch),
      .abort_o      (abort),
      .kind_o       (kind),
      .req_o        (prog_req),
      .limit_o      (limit),
      .win_dis_o    (win_disable),
      .irq_o        (irq)
   );

   cfg_pio_timer #(
      .TMO_W (TMO_W),
      .EN    (TIMEOUT_EN)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .launch_i (launch),
      .busy_i   (busy),
      .limit_i  (limit),
      .expire_o (expire)
   );

   cfg_pio_fsm u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .launch_i     (launch),
      .abort_i      (abort),
      .kind_i       (kind),
      .req_i        (prog_req),
      .expire_i     (expire),
      .req_ready    (req_ready),
      .rsp_valid    (rsp_valid),
      .rsp_data     (rsp_data),
      .rsp_status   (rsp_status),
      .busy_o       (busy),
      .done_o       (done),
      .cpl_o        (cpl),
      .rdata_load_o (rd_load),
      .rdata_o      (rd_val),
      .req_valid    (req_valid),
      .req_write    (req_write),
      .req_type1    (req_type1),
      .req_o        (live_req)
   );

   assign req_addr_lo = live_req.addr_lo;
   assign req_addr_hi = live_req.addr_hi;
   assign req_wdata   = live_req.wdata;
   assign req_strb    = live_req.strb;

endmodule

// File: tb/cfg_pio_engine_tb.sv
module cfg_pio_engine_tb;

   localparam int CLK_P = 10;

   localparam logic [5:0] GO = 6'h00, CTRL = 6'h04, IRQS = 6'h08, CPLS = 6'h0C,
                          ALO = 6'h10, AHI = 6'h14, WDAT = 6'h18, BEN = 6'h1C,
                          RDAT = 6'h20, LIM = 6'h24;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [5:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq, win_disable, req_valid, req_write, req_type1;
   logic        req_ready = 1'b0;
   logic [31:0] req_addr_lo, req_addr_hi, req_wdata;
   logic [3:0]  req_strb;
   logic        rsp_valid = 1'b0;
   logic [31:0] rsp_data = '0;
   logic [2:0]  rsp_status = '0;

   int n_chk = 0;
   int n_fail = 0;
   int hs_cnt = 0;
   logic [31:0] exp_rd = '0;
   logic [31:0] v;

   always #(CLK_P/2) clk = ~clk;

   always @(posedge clk) if (req_valid && req_ready) hs_cnt <= hs_cnt + 1;

   cfg_pio_engine u_dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
      .win_disable(win_disable), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_type1(req_type1), .req_addr_lo(req_addr_lo),
      .req_addr_hi(req_addr_hi), .req_wdata(req_wdata), .req_strb(req_strb),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_status(rsp_status)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic launch(input logic [3:0] kind);
      wr(CTRL, {28'h0, kind});
      wr(GO, 32'h1);
   endtask

   task automatic accept();
      @(negedge clk); req_ready = 1'b1;
      @(negedge clk); req_ready = 1'b0;
   endtask

   task automatic respond(input logic [31:0] d, input logic [2:0] s);
      @(negedge clk); rsp_valid = 1'b1; rsp_data = d; rsp_status = s;
      @(negedge clk); rsp_valid = 1'b0;
   endtask

   task automatic t_reset();
      rd(GO, v);   chk("R1 go", v, 0);
      rd(IRQS, v); chk("R1 irqstat", v, 0);
      rd(CPLS, v); chk("R1 cplstat", v, 0);
      rd(RDAT, v); chk("R1 rdata", v, 0);
      rd(CTRL, v); chk("R1 ctrl", v, 0);
      rd(BEN, v);  chk("R1 byteen", v, 32'hF);
      rd(LIM, v);  chk("R1 limit", v, 32'd1000);
      chk("R1 req_valid", {31'h0, req_valid}, 0);
      chk("R1 irq", {31'h0, irq}, 0);
      chk("R1 win", {31'h0, win_disable}, 0);
   endtask

   task automatic t_ctrl();
      wr(CTRL, 32'h0100000A);
      rd(CTRL, v); chk("R3 ctrl readback", v, 32'h0100000A);
      chk("R3 win set", {31'h0, win_disable}, 1);
      wr(CTRL, 32'hFFFFFFFF);
      rd(CTRL, v); chk("R3 ctrl other bits zero", v, 32'h0100000F);
      wr(CTRL, 32'h00000009);
      rd(CTRL, v); chk("R3 ctrl kind only", v, 32'h9);
      chk("R3 win clear", {31'h0, win_disable}, 0);
   endtask

   task automatic t_read0();
      logic [31:0] a0;
      int h0;
      a0 = (32'd1 << 20) | (32'd3 << 15) | (32'd2 << 12) | 32'h10;
      wr(BEN, 32'hF); wr(AHI, 32'h0); wr(ALO, a0); wr(WDAT, 32'h0);
      h0 = hs_cnt;
      launch(4'h8);
      chk("R4 req_valid", {31'h0, req_valid}, 1);
      chk("R2 rd0 write", {31'h0, req_write}, 0);
      chk("R2 rd0 type1", {31'h0, req_type1}, 0);
      chk("R4 addr_lo", req_addr_lo, a0);
      chk("R4 bus field", {24'h0, req_addr_lo[27:20]}, 1);
      chk("R4 dev field", {27'h0, req_addr_lo[19:15]}, 3);
      chk("R4 strb", {28'h0, req_strb}, 32'hF);
      repeat (3) @(negedge clk);
      chk("R4 req held", {31'h0, req_valid}, 1);
      rd(GO, v); chk("R4 go busy", v, 1);
      wr(GO, 32'h1);
      wr(ALO, 32'hDEAD0000);
      chk("R8 addr frozen", req_addr_lo, a0);
      accept();
      chk("R4 req dropped", {31'h0, req_valid}, 0);
      chk("R8 one request", hs_cnt - h0, 1);
      respond(32'hCAFE0001, 3'b000);
      chk("R5 irq", {31'h0, irq}, 1);
      rd(GO, v);   chk("R5 go cleared", v, 0);
      rd(IRQS, v); chk("R5 irqstat", v, 1);
      exp_rd = 32'hCAFE0001;
      rd(RDAT, v); chk("R5 rdata", v, exp_rd);
      rd(CPLS, v); chk("R5 cplstat ok", v, 0);
   endtask

   task automatic t_irq_clear();
      wr(IRQS, 32'h0);
      rd(IRQS, v); chk("R6 write0 no effect", v, 1);
      wr(IRQS, 32'h1);
      rd(IRQS, v); chk("R6 w1c", v, 0);
      chk("R6 irq low", {31'h0, irq}, 0);
   endtask

   task automatic t_write1();
      logic [31:0] a1;
      a1 = (32'd2 << 20) | 32'h04;
      wr(ALO, a1); wr(WDAT, 32'h12345678); wr(BEN, 32'h3);
      launch(4'hB);
      chk("R2 wr1 write", {31'h0, req_write}, 1);
      chk("R2 wr1 type1", {31'h0, req_type1}, 1);
      chk("R4 wdata", req_wdata, 32'h12345678);
      chk("R4 strb partial", {28'h0, req_strb}, 32'h3);
      chk("R4 addr_lo", req_addr_lo, a1);
      accept();
      respond(32'h55AA55AA, 3'b010);
      rd(CPLS, v); chk("R5 cplstat field", v, 32'h100);
      rd(RDAT, v); chk("R7 rdata kept", v, exp_rd);
      chk("R5 irq after write", {31'h0, irq}, 1);
      launch(4'hA);
      chk("R2 wr0 write", {31'h0, req_write}, 1);
      chk("R2 wr0 type1", {31'h0, req_type1}, 0);
      accept();
      respond(32'h0, 3'b000);
   endtask

   task automatic t_read1_setwins();
      wr(IRQS, 32'h1);
      wr(BEN, 32'hF);
      launch(4'h9);
      chk("R2 rd1 write", {31'h0, req_write}, 0);
      chk("R2 rd1 type1", {31'h0, req_type1}, 1);
      accept();
      @(negedge clk);
      rsp_valid = 1'b1; rsp_data = 32'h0BADF00D; rsp_status = 3'b000;
      reg_we = 1'b1; reg_addr = IRQS; reg_wdata = 32'h1;
      @(negedge clk);
      rsp_valid = 1'b0; reg_we = 1'b0; reg_wdata = '0;
      rd(IRQS, v); chk("R6 set wins", v, 1);
      exp_rd = 32'h0BADF00D;
      rd(RDAT, v); chk("R5 rdata type1", v, exp_rd);
   endtask

   task automatic t_abort();
      wr(IRQS, 32'h1);
      launch(4'h8);
      accept();
      wr(GO, 32'h0);
      rd(GO, v); chk("R9 go after abort", v, 0);
      respond(32'h11111111, 3'b000);
      rd(IRQS, v); chk("R9 no irqstat", v, 0);
      rd(RDAT, v); chk("R9 stray ignored", v, exp_rd);
      chk("R9 irq low", {31'h0, irq}, 0);
      launch(4'h8);
      wr(GO, 32'h0);
      chk("R9 req dropped", {31'h0, req_valid}, 0);
   endtask

   task automatic t_timeout();
      wr(LIM, 32'd20);
      wr(IRQS, 32'h1);
      launch(4'h8);
      repeat (19) @(posedge clk);
      @(negedge clk);
      chk("R10 pending before limit", {30'h0, req_valid, irq}, 32'h2);
      @(posedge clk);
      @(negedge clk);
      chk("R10 done at limit", {30'h0, req_valid, irq}, 32'h1);
      exp_rd = 32'hFFFFFFFF;
      rd(RDAT, v); chk("R10 rdata ones", v, exp_rd);
      rd(CPLS, v); chk("R10 cpl code", v, 32'h280);
   endtask

   task automatic t_no_timeout();
      wr(LIM, 32'd0);
      wr(IRQS, 32'h1);
      launch(4'h8);
      repeat (300) @(negedge clk);
      chk("R10 limit0 waits", {30'h0, req_valid, irq}, 32'h2);
      wr(GO, 32'h0);
      rd(IRQS, v); chk("R10 limit0 no irq", v, 0);
   endtask

   task automatic t_badkind();
      int h;
      wr(IRQS, 32'h1);
      h = hs_cnt;
      launch(4'h3);
      chk("R11 no request", {31'h0, req_valid}, 0);
      chk("R11 irq", {31'h0, irq}, 1);
      rd(GO, v);   chk("R11 go", v, 0);
      rd(CPLS, v); chk("R11 cpl code", v, 32'h380);
      rd(RDAT, v); chk("R11 rdata kept", v, exp_rd);
      chk("R11 no handshake", hs_cnt - h, 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_ctrl();
      t_read0();
      t_irq_clear();
      t_write1();
      t_read1_setwins();
      t_abort();
      t_timeout();
      t_no_timeout();
      t_badkind();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(CLK_P * 150000);
      n_fail++;
      $display("FAIL watchdog expired got=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule